// File: doc/BRIEF.md
# Byte-Indexed Bit Gather Unit

This block collects eight single bits from a 64-bit data word and returns them packed into one byte. The positions of those bits come from a second 64-bit operand, the index word. Each of the eight bytes of the index word is one unsigned bit address into the data word. An address that falls outside the data word contributes a zero, so software can mask a lane by writing any byte value of 64 or more.

Both operands use most-significant-first numbering. Index byte 0 is the top byte of the index word, and data bit 0 is the top bit of the data word. The eight gathered bits fill the lowest byte of the 64-bit result, with gathered bit 0 in the highest position of that byte. The upper 56 result bits are always zero. No flags or condition state are produced. A parameter selects between a purely combinational path and one output register. A second parameter selects how each lane's bit select is built: an indexed multiplexer or a one-hot AND-OR tree.

Top module: `bitperm_gather`

## Requirements
- R1: Lane i (i = 0..7) takes its address from index word bits [63-8i : 56-8i] in Verilog numbering. Lane 0 therefore uses the most significant byte.
- R2: When a lane's address A, read as unsigned, is below 64, the lane's bit equals data word bit [63-A] in Verilog numbering. Address 0 selects the most significant data bit, and address 63 selects the least significant one.
- R3: When a lane's address is 64 or more (for example 64, 71 or 255), the lane's bit is 0, whatever the data word holds.
- R4: Lane i's bit drives result bit [7-i]. Lane 0 lands in result bit 7, and lane 7 lands in result bit 0.
- R5: Result bits [63:8] are zero for every input.
- R6: With REGISTERED=1 the result reflects the operands present at the previous rising clock edge and holds between edges. With REGISTERED=0 the result follows the operands in the same cycle.
- R7: With REGISTERED=1, an active-low rst_n clears the result to zero.
- R8: Lanes are independent: several lanes may carry the same address, and each then returns the same data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| idx_word | input | 64 | Eight byte-wide bit addresses, lane 0 in the top byte |
| data_word | input | 64 | Word the bits are gathered from, bit 0 = most significant |
| result | output | 64 | Gathered byte in bits [7:0], zeros above |

## Verification
The bench builds two copies side by side from the same stimulus. One uses the defaults (registered output, indexed multiplexer). The other is combinational and uses the one-hot select tree. Together they reach both generate branches of the output stage and both lane select variants. They also let the bench confirm the one-cycle offset and the hold behaviour against the same-cycle path. The random addresses are weighted towards the 63/64 boundary and towards 255, so the range check in every lane sees both sides of the limit many times.

// File: rtl/bp_pkg.sv
package bp_pkg;

   // lane select implementation choices
   localparam int SEL_INDEXED = 0;
   localparam int SEL_ONEHOT  = 1;

   function automatic bit bp_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bp_lane.sv
// One gather lane: turns a byte-wide address into one data bit (R2, R3).
module bp_lane
   import bp_pkg::*;
#(
   parameter int WORD_W    = 64,
   parameter int IDX_W     = 8,
   parameter int SEL_STYLE = SEL_INDEXED
) (
   input  logic [IDX_W-1:0]  sel,
   input  logic [WORD_W-1:0] data,
   output logic              bit_o
);

   localparam int ADDR_W = $clog2(WORD_W);

   // data_msb[k] is data bit k counted from the most significant end
   logic [WORD_W-1:0] data_msb;
   logic              in_range;
   logic [ADDR_W-1:0] addr;

   always_comb begin
      for (int k = 0; k < WORD_W; k++) begin
         data_msb[k] = data[WORD_W-1-k];
      end
   end

   assign addr = sel[ADDR_W-1:0];

   // WORD_W is a power of two, so "below WORD_W" means "no bit above ADDR_W set"
   generate
      if (IDX_W > ADDR_W) begin : g_rng_chk
         assign in_range = (sel[IDX_W-1:ADDR_W] == '0);
      end else begin : g_rng_all
         assign in_range = 1'b1;
      end
   endgenerate

   generate
      if (SEL_STYLE == SEL_ONEHOT) begin : g_onehot
         logic [WORD_W-1:0] hit;
         for (genvar k = 0; k < WORD_W; k++) begin : g_hit
            assign hit[k] = in_range && (addr == ADDR_W'(k)) && data_msb[k];
         end
         assign bit_o = |hit;
      end else begin : g_indexed
         assign bit_o = in_range & data_msb[addr];
      end
   endgenerate

endmodule

// File: rtl/bp_pack.sv
// Places lane bits into the low end of the result, lane 0 highest (R4, R5).
module bp_pack #(
   parameter int WORD_W = 64,
   parameter int LANES  = 8
) (
   input  logic [LANES-1:0]  lane_bits,
   output logic [WORD_W-1:0] packed_o
);

   for (genvar i = 0; i < LANES; i++) begin : g_place
      assign packed_o[LANES-1-i] = lane_bits[i];
   end

   generate
      if (WORD_W > LANES) begin : g_pad
         assign packed_o[WORD_W-1:LANES] = '0;
      end
   endgenerate

endmodule

// File: rtl/bp_stage.sv
// Single output register with asynchronous active-low clear (R6, R7).
module bp_stage #(
   parameter int WORD_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end

endmodule

// File: rtl/bitperm_gather.sv
module bitperm_gather
   import bp_pkg::*;
#(
   parameter int WORD_W     = 64,
   parameter int IDX_W      = 8,
   parameter int REGISTERED = 1,
   parameter int SEL_STYLE  = SEL_INDEXED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] idx_word,
   input  logic [WORD_W-1:0] data_word,
   output logic [WORD_W-1:0] result
);

   localparam int LANES = WORD_W / IDX_W;

   // elaboration-time parameter checks
   generate
      if (!bp_is_pow2(WORD_W)) begin : g_bad_word
         $error("bitperm_gather: WORD_W must be a power of two");
      end
      if ((WORD_W % IDX_W) != 0) begin : g_bad_split
         $error("bitperm_gather: WORD_W must split evenly into IDX_W lanes");
      end
      if (IDX_W < 1 || IDX_W > 30 || (1 << IDX_W) < WORD_W) begin : g_bad_idx
         $error("bitperm_gather: IDX_W cannot address every data bit");
      end
      if (REGISTERED != 0 && REGISTERED != 1) begin : g_bad_reg
         $error("bitperm_gather: REGISTERED must be 0 or 1");
      end
      if (SEL_STYLE != SEL_INDEXED && SEL_STYLE != SEL_ONEHOT) begin : g_bad_sel
         $error("bitperm_gather: unknown SEL_STYLE");
      end
   endgenerate

   logic [LANES-1:0]  lane_bits;
   logic [WORD_W-1:0] gathered;

   // R1: lane i reads its address from the i-th byte counted from the top
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      bp_lane #(
         .WORD_W   (WORD_W),
         .IDX_W    (IDX_W),
         .SEL_STYLE(SEL_STYLE)
      ) u_lane (
         .sel  (idx_word[WORD_W-1-IDX_W*i -: IDX_W]),
         .data (data_word),
         .bit_o(lane_bits[i])
      );
   end

   bp_pack #(
      .WORD_W(WORD_W),
      .LANES (LANES)
   ) u_pack (
      .lane_bits(lane_bits),
      .packed_o (gathered)
   );

   // operands the current result was formed from, for the checks below
   logic [WORD_W-1:0] chk_idx;
   logic [WORD_W-1:0] chk_data;
   logic              chk_live;

   generate
      if (REGISTERED == 1) begin : g_reg
         bp_stage #(
            .WORD_W(WORD_W)
         ) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (gathered),
            .q    (result)
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chk_idx  <= '0;
               chk_data <= '0;
               chk_live <= 1'b0;
            end else begin
               chk_idx  <= idx_word;
               chk_data <= data_word;
               chk_live <= 1'b1;
            end
         end

         assert_reset_clear_R7 : assert property (
            @(posedge clk) !rst_n |=> (result == '0)
         ) else $error("R7: result not cleared by reset");
      end else begin : g_comb
         assign result   = gathered;
         assign chk_idx  = idx_word;
         assign chk_data = data_word;
         assign chk_live = 1'b1;
      end
   endgenerate

   assert_upper_zero_R5 : assert property (
      @(posedge clk) disable iff (!rst_n)
      result[WORD_W-1:LANES] == '0
   ) else $error("R5: upper result bits not zero");

   for (genvar i = 0; i < LANES; i++) begin : g_chk
      logic [IDX_W-1:0] cb;
      assign cb = chk_idx[WORD_W-1-IDX_W*i -: IDX_W];

      assert_oob_zero_R3 : assert property (
         @(posedge clk) disable iff (!rst_n)
         (chk_live && int'(cb) >= WORD_W) |-> !result[LANES-1-i]
      ) else $error("R3: out-of-range lane %0d not zero", i);

      // R4: lane i lands in result bit LANES-1-i
      assert_pick_bit_R2 : assert property (
         @(posedge clk) disable iff (!rst_n)
         (chk_live && int'(cb) < WORD_W) |->
            (result[LANES-1-i] == chk_data[WORD_W-1-int'(cb)])
      ) else $error("R2: lane %0d picked the wrong data bit", i);
   end

endmodule

// File: tb/tb_bitperm_gather.sv
module tb_bitperm_gather;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic        rst_n;
   logic [63:0] idx_w;
   logic [63:0] data_w;
   logic [63:0] res_r;
   logic [63:0] res_c;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   logic [63:0] prev_exp;

   bitperm_gather #(.REGISTERED(1), .SEL_STYLE(0)) dut (
      .clk(clk), .rst_n(rst_n), .idx_word(idx_w), .data_word(data_w), .result(res_r)
   );

   bitperm_gather #(.REGISTERED(0), .SEL_STYLE(1)) dut_c (
      .clk(clk), .rst_n(rst_n), .idx_word(idx_w), .data_word(data_w), .result(res_c)
   );

   // reference: address byte i counted from the top, data bit 0 = MSB,
   // gathered bit i written to result bit 7-i, all else zero
   function automatic logic [63:0] model(input logic [63:0] ix, input logic [63:0] dw);
      logic [63:0] r = '0;
      for (int i = 0; i < 8; i++) begin
         int unsigned a = (ix >> (56 - 8 * i)) & 64'hFF;
         if (a < 64) begin
            r = r | ((((dw >> (63 - a)) & 64'd1)) << (7 - i));
         end
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input string req, input logic [63:0] ix, input logic [63:0] dw);
      logic [63:0] e = model(ix, dw);
      @(negedge clk);
      idx_w  = ix;
      data_w = dw;
      #1;
      check({req, " R6 same-cycle"}, res_c, e);
      check("R6 registered hold", res_r, prev_exp);
      @(negedge clk);
      check({req, " R6 registered"}, res_r, e);
      prev_exp = e;
   endtask

   function automatic logic [7:0] pick_addr();
      case ($urandom % 4)
         0:       return 8'($urandom % 64);
         1:       return 8'(60 + $urandom % 8);
         2: begin
            case ($urandom % 4)
               0:       return 8'd0;
               1:       return 8'd63;
               2:       return 8'd64;
               default: return 8'd255;
            endcase
         end
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R6: watchdog expired, actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      rst_n  = 1'b0;
      idx_w  = 64'h0001_0203_0405_0607;
      data_w = '1;
      repeat (3) @(negedge clk);
      check("R7 reset clear", res_r, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      prev_exp = model(idx_w, data_w);

      // R1, R4: lane 0 at address 0 reads MSB, lands in result bit 7
      apply("R1 R4 lane0", 64'h0001_0203_0405_0607, 64'h8000_0000_0000_0000);
      check("R4 lane0 value", res_r, 64'h80);
      // R1, R4: lane 7 at address 7 lands in result bit 0
      apply("R1 R4 lane7", 64'h0001_0203_0405_0607, 64'h0100_0000_0000_0000);
      check("R4 lane7 value", res_r, 64'h01);
      // R2: address 63 is the least significant data bit
      apply("R2 addr63", 64'h3F3F_3F3F_3F3F_3F3F, 64'h1);
      check("R2 addr63 value", res_r, 64'hFF);
      apply("R2 addr63 clear", 64'h3F3F_3F3F_3F3F_3F3F, ~64'h1);
      // R3: addresses 64 and 255 give zero on an all-ones word
      apply("R3 addr64", 64'h4040_4040_4040_4040, '1);
      check("R3 addr64 value", res_r, 64'h0);
      apply("R3 addr255", '1, '1);
      apply("R3 mixed", 64'h3F40_3F40_3F40_3F40, '1);
      check("R3 mixed value", res_r, 64'hAA);
      // R8: every lane names the same address
      apply("R8 duplicate", 64'h0505_0505_0505_0505, 64'h0400_0000_0000_0000);
      check("R8 duplicate value", res_r, 64'hFF);
      // R5: all-ones data, upper bits must stay clear
      apply("R5 upper zero", 64'h0008_1018_2028_3038, '1);
      check("R5 upper value", res_r, 64'hFF);

      for (int n = 0; n < 400; n++) begin
         logic [63:0] ix;
         for (int b = 0; b < 8; b++) ix[8*b +: 8] = pick_addr();
         apply("R2 R3 random", ix, {$urandom, $urandom});
      end

      // R7: reset in mid-run clears the registered output
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R7 async clear", res_r, 64'h0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule